// File: doc/BRIEF.md
# Four-Channel Burst DMA Engine

This block is a four-channel DMA engine that masters a simple read/write memory bus. Software loads each channel's source address, destination address, word count and next-descriptor pointer, then writes a control word that enables the channel and picks its mode. The four modes are memory-to-memory copy, fill with a constant word, dual-address transfer paced by a device request, and single-address (fly-by) transfer paced by a device request. In fly-by mode the device is strobed while the engine accesses memory.

Data moves in bursts of at most eight words. A channel gives up the bus at the end of each burst, and a fixed-priority arbiter then chooses the next channel, with channel 0 highest. When a channel's count reaches zero and its next pointer is nonzero, the engine reads a four-word descriptor from that pointer and carries on. When the pointer is zero, the channel stops and pulses its completion interrupt.

Top module: `dma_engine`

## Requirements
- R1: Copy mode (control mode 0) reads `count` 32-bit words from consecutive word addresses starting at the source and writes them in order to consecutive word addresses starting at the destination, for any word-aligned start address. Words outside the destination range are left unchanged.
- R2: A transfer of N words uses ceil(N/8) bursts. Each burst holds min(remaining, 8) beats per direction. The bus request drops for at least one cycle between bursts.
- R3: When several channels request in the same cycle, the lowest-numbered channel gets the next burst.
- R4: Fill mode (control mode 1) writes the value held in the source register to `count` consecutive words from the destination, and reads nothing.
- R5: Paced modes (2 and 3) move data only on channels 0 and 1, and only while `ext_req` for that channel is high when arbitration takes place. A paced channel 2 or 3 with a nonzero count performs no bus access.
- R6: Dual-address mode (mode 2) moves data in the same way as copy mode: it reads from the source range and writes to the destination range.
- R7: In fly-by mode (mode 3), with control bit 3 clear, `dev_wdata` is written to `count` words from the destination. With the bit set, those words are only read. In both cases `dev_ack[ch]` is high on exactly one accepted beat per word, and only while a memory beat is in progress.
- R8: When a channel's count is zero and its next pointer is nonzero, the engine reads four words from the pointer. These are loaded, in order, as source, destination, count and next pointer, and the transfer continues.
- R9: When a channel's count is zero and its next pointer is zero, `irq[ch]` pulses high for one cycle and the channel is disabled. No bus access occurs, even if the channel was started with count zero.
- R10: While `m_req` is high and `m_ack` is low, `m_addr` and `m_we` hold their values into the next cycle.
- R11: Out of reset all channels are disabled, and `m_req`, `irq` and `dev_ack` are low.
- R12: A configuration write stores `cfg_wdata` into the register of channel `cfg_ch` chosen by `cfg_sel`: 0 source, 1 destination, 2 count (in words), 3 next pointer, 4 control. In the control word, bit 0 enables the channel, bits 2:1 select the mode and bit 3 selects the fly-by direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 3 | Register select within the channel |
| cfg_wdata | input | 32 | Configuration write data |
| ext_req | input | 2 | Device request for channels 0 and 1 |
| dev_wdata | input | 32 | Device data for fly-by writes to memory |
| dev_ack | output | 4 | Per-channel fly-by strobe during memory beats |
| irq | output | 4 | Per-channel completion pulse |
| m_req | output | 1 | Bus beat request |
| m_we | output | 1 | Beat is a write |
| m_addr | output | 32 | Byte address of the beat |
| m_wdata | output | 32 | Write data |
| m_rdata | input | 32 | Read data, valid with m_ack |
| m_ack | input | 1 | Beat accepted this cycle |

## Verification
The assertions check the bus-level rules on every cycle: address and direction hold while a beat is stalled; no run of same-direction beats exceeds eight; fly-by strobes are one-hot and appear only during beats; channels 2 and 3 never receive a strobe; interrupts are one-hot and never coincide with bus traffic. Only the bench scenarios can show that data lands at the right addresses. These scenarios cover burst counts over a sweep of copy and fill lengths, the loading of a chained descriptor, the arbitration order when two paced channels are released together, and the exact number of fly-by strobes per transfer.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    MD_COPY  = 2'd0,
    MD_FILL  = 2'd1,
    MD_DUAL  = 2'd2,
    MD_FLYBY = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_FETCH,
    ST_UPD
  } eng_state_e;

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_CNT  = 3'd2;
  localparam logic [2:0] SEL_NEXT = 3'd3;
  localparam logic [2:0] SEL_CTRL = 3'd4;

  localparam int DESC_WORDS = 4;

  function automatic logic mode_is_paced(xfer_mode_e m);
    return (m == MD_DUAL) || (m == MD_FLYBY);
  endfunction

endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CW     = 16,
  parameter bit EXT_OK = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          upd_en,
  input  logic          upd_fin,
  input  logic [AW-1:0] upd_src,
  input  logic [AW-1:0] upd_dst,
  input  logic [CW-1:0] upd_cnt,
  input  logic [AW-1:0] upd_next,
  input  logic          ext_req_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output logic [AW-1:0] next_o,
  output xfer_mode_e    mode_o,
  output logic          dir_o,
  output logic          req_o
);

  logic [AW-1:0] src_q, src_d, dst_q, dst_d, next_q, next_d;
  logic [CW-1:0] cnt_q, cnt_d;
  xfer_mode_e    mode_q, mode_d;
  logic          dir_q, dir_d, en_q, en_d;
  logic          load;
  logic          pace_ok;

  assign load = upd_en | wr_en;

  always_comb begin
    src_d  = src_q;
    dst_d  = dst_q;
    cnt_d  = cnt_q;
    next_d = next_q;
    mode_d = mode_q;
    dir_d  = dir_q;
    en_d   = en_q;
    if (upd_en) begin
      src_d  = upd_src;
      dst_d  = upd_dst;
      cnt_d  = upd_cnt;
      next_d = upd_next;
      if (upd_fin) en_d = 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_SRC:  src_d  = wr_data;
        SEL_DST:  dst_d  = wr_data;
        SEL_CNT:  cnt_d  = wr_data[CW-1:0];
        SEL_NEXT: next_d = wr_data;
        SEL_CTRL: begin
          en_d   = wr_data[0];
          mode_d = xfer_mode_e'(wr_data[2:1]);
          dir_d  = wr_data[3];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      next_q <= '0;
      mode_q <= MD_COPY;
      dir_q  <= 1'b0;
      en_q   <= 1'b0;
    end else if (load) begin
      src_q  <= src_d;
      dst_q  <= dst_d;
      cnt_q  <= cnt_d;
      next_q <= next_d;
      mode_q <= mode_d;
      dir_q  <= dir_d;
      en_q   <= en_d;
    end
  end

  assign pace_ok = EXT_OK ? ext_req_i : 1'b0;
  assign req_o   = en_q & ((cnt_q == '0) | (mode_is_paced(mode_q) ? pace_ok : 1'b1));

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign cnt_o  = cnt_q;
  assign next_o = next_q;
  assign mode_o = mode_q;
  assign dir_o  = dir_q;

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CW   = 16,
  parameter int MAXB = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [CHW-1:0] start_ch,
  input  logic [AW-1:0]  c_src,
  input  logic [AW-1:0]  c_dst,
  input  logic [CW-1:0]  c_cnt,
  input  logic [AW-1:0]  c_next,
  input  xfer_mode_e     c_mode,
  input  logic           c_dir,
  input  logic [DW-1:0]  dev_wdata,
  input  logic [DW-1:0]  m_rdata,
  input  logic           m_ack,
  output logic           busy,
  output logic           m_req,
  output logic           m_we,
  output logic [AW-1:0]  m_addr,
  output logic [DW-1:0]  m_wdata,
  output logic [NCH-1:0] dev_ack,
  output logic           upd_en,
  output logic [CHW-1:0] upd_ch,
  output logic           upd_fin,
  output logic [AW-1:0]  upd_src,
  output logic [AW-1:0]  upd_dst,
  output logic [CW-1:0]  upd_cnt,
  output logic [AW-1:0]  upd_next,
  output logic [NCH-1:0] irq
);

  localparam int BUFD  = (MAXB > DESC_WORDS) ? MAXB : DESC_WORDS;
  localparam int BW    = $clog2(BUFD + 1);
  localparam int IXW   = $clog2(BUFD);
  localparam int BYTES = DW / 8;

  eng_state_e     st_q, st_d;
  logic [CHW-1:0] ch_q, ch_d;
  logic [AW-1:0]  src_q, src_d, dst_q, dst_d, next_q, next_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  xfer_mode_e     mode_q, mode_d;
  logic           dir_q, dir_d;
  logic [BW-1:0]  len_q, len_d, beat_q, beat_d;
  logic           fin_q, fin_d, load_q, load_d;
  logic           ctl_en;
  logic [DW-1:0]  buf_q [BUFD];
  logic           buf_we;
  logic [IXW-1:0] bix;
  logic           last_beat;
  logic [BW-1:0]  len_new;
  logic [AW-1:0]  base, step;

  assign bix       = beat_q[IXW-1:0];
  assign last_beat = (beat_q == len_q - BW'(1));
  assign len_new   = (c_cnt > CW'(MAXB)) ? BW'(MAXB) : BW'(c_cnt);

  // next-state logic
  always_comb begin
    st_d   = st_q;
    ch_d   = ch_q;
    src_d  = src_q;
    dst_d  = dst_q;
    cnt_d  = cnt_q;
    next_d = next_q;
    mode_d = mode_q;
    dir_d  = dir_q;
    len_d  = len_q;
    beat_d = beat_q;
    fin_d  = fin_q;
    load_d = load_q;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          ch_d   = start_ch;
          src_d  = c_src;
          dst_d  = c_dst;
          cnt_d  = c_cnt;
          next_d = c_next;
          mode_d = c_mode;
          dir_d  = c_dir;
          beat_d = '0;
          fin_d  = 1'b0;
          load_d = 1'b0;
          if (c_cnt == '0) begin
            if (c_next == '0) begin
              fin_d = 1'b1;
              st_d  = ST_UPD;
            end else begin
              load_d = 1'b1;
              len_d  = BW'(DESC_WORDS);
              st_d   = ST_FETCH;
            end
          end else begin
            len_d = len_new;
            if (c_mode == MD_FILL || (c_mode == MD_FLYBY && !c_dir)) st_d = ST_WR;
            else st_d = ST_RD;
          end
        end
      end
      ST_RD: begin
        if (m_ack) begin
          if (last_beat) begin
            beat_d = '0;
            st_d   = (mode_q == MD_FLYBY) ? ST_UPD : ST_WR;
          end else begin
            beat_d = beat_q + BW'(1);
          end
        end
      end
      ST_WR, ST_FETCH: begin
        if (m_ack) begin
          if (last_beat) begin
            beat_d = '0;
            st_d   = ST_UPD;
          end else begin
            beat_d = beat_q + BW'(1);
          end
        end
      end
      ST_UPD:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign ctl_en = (st_q == ST_IDLE) ? start : ((st_q == ST_UPD) | m_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ch_q   <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      next_q <= '0;
      mode_q <= MD_COPY;
      dir_q  <= 1'b0;
      len_q  <= '0;
      beat_q <= '0;
      fin_q  <= 1'b0;
      load_q <= 1'b0;
    end else if (ctl_en) begin
      st_q   <= st_d;
      ch_q   <= ch_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      cnt_q  <= cnt_d;
      next_q <= next_d;
      mode_q <= mode_d;
      dir_q  <= dir_d;
      len_q  <= len_d;
      beat_q <= beat_d;
      fin_q  <= fin_d;
      load_q <= load_d;
    end
  end

  // burst buffer: data storage, not reset
  assign buf_we = m_ack & ((st_q == ST_RD) | (st_q == ST_FETCH));

  always_ff @(posedge clk) begin
    if (buf_we) buf_q[bix] <= m_rdata;
  end

  // bus side
  always_comb begin
    case (st_q)
      ST_FETCH: base = next_q;
      ST_RD:    base = (mode_q == MD_FLYBY) ? dst_q : src_q;
      default:  base = dst_q;
    endcase
  end

  assign busy   = (st_q != ST_IDLE);
  assign m_req  = (st_q == ST_RD) | (st_q == ST_WR) | (st_q == ST_FETCH);
  assign m_we   = (st_q == ST_WR);
  assign m_addr = base + (AW'(beat_q) * AW'(BYTES));

  always_comb begin
    case (mode_q)
      MD_FILL:  m_wdata = DW'(src_q);
      MD_FLYBY: m_wdata = dev_wdata;
      default:  m_wdata = buf_q[bix];
    endcase
  end

  always_comb begin
    dev_ack = '0;
    if (mode_q == MD_FLYBY && (st_q == ST_RD || st_q == ST_WR)) dev_ack[ch_q] = 1'b1;
  end

  // register update at the end of a burst, fetch or chain
  assign step    = AW'(len_q) * AW'(BYTES);
  assign upd_en  = (st_q == ST_UPD);
  assign upd_ch  = ch_q;
  assign upd_fin = upd_en & fin_q;

  always_comb begin
    irq = '0;
    if (upd_fin) irq[ch_q] = 1'b1;
  end

  always_comb begin
    if (load_q) begin
      upd_src  = AW'(buf_q[0]);
      upd_dst  = AW'(buf_q[1]);
      upd_cnt  = buf_q[2][CW-1:0];
      upd_next = AW'(buf_q[3]);
    end else if (fin_q) begin
      upd_src  = src_q;
      upd_dst  = dst_q;
      upd_cnt  = cnt_q;
      upd_next = next_q;
    end else begin
      upd_src  = (mode_q == MD_COPY || mode_q == MD_DUAL) ? src_q + step : src_q;
      upd_dst  = dst_q + step;
      upd_cnt  = cnt_q - CW'(len_q);
      upd_next = next_q;
    end
  end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NEXT = 2,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CW   = 16,
  parameter int MAXB = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [2:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic [NEXT-1:0] ext_req,
  input  logic [DW-1:0]  dev_wdata,
  output logic [NCH-1:0] dev_ack,
  output logic [NCH-1:0] irq,
  output logic           m_req,
  output logic           m_we,
  output logic [AW-1:0]  m_addr,
  output logic [DW-1:0]  m_wdata,
  input  logic [DW-1:0]  m_rdata,
  input  logic           m_ack
);

  logic rs1_q, rs2_q, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_core_n = rs2_q;

  logic [AW-1:0]  ch_src  [NCH];
  logic [AW-1:0]  ch_dst  [NCH];
  logic [AW-1:0]  ch_next [NCH];
  logic [CW-1:0]  ch_cnt  [NCH];
  xfer_mode_e     ch_mode [NCH];
  logic [NCH-1:0] ch_dir, ch_req;

  logic           e_busy, e_upd_en, e_upd_fin;
  logic [CHW-1:0] e_upd_ch;
  logic [AW-1:0]  e_upd_src, e_upd_dst, e_upd_next;
  logic [CW-1:0]  e_upd_cnt;
  logic           arb_any, start;
  logic [CHW-1:0] arb_idx;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic ext_g;
    if (g < NEXT) begin : g_ext
      assign ext_g = ext_req[g];
    end else begin : g_noext
      assign ext_g = 1'b0;
    end

    dma_chan_regs #(
      .AW(AW), .CW(CW), .EXT_OK(g < NEXT)
    ) u_regs (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .wr_en    (cfg_we & (cfg_ch == CHW'(g))),
      .wr_sel   (cfg_sel),
      .wr_data  (cfg_wdata),
      .upd_en   (e_upd_en & (e_upd_ch == CHW'(g))),
      .upd_fin  (e_upd_fin),
      .upd_src  (e_upd_src),
      .upd_dst  (e_upd_dst),
      .upd_cnt  (e_upd_cnt),
      .upd_next (e_upd_next),
      .ext_req_i(ext_g),
      .src_o    (ch_src[g]),
      .dst_o    (ch_dst[g]),
      .cnt_o    (ch_cnt[g]),
      .next_o   (ch_next[g]),
      .mode_o   (ch_mode[g]),
      .dir_o    (ch_dir[g]),
      .req_o    (ch_req[g])
    );
  end

  dma_prio_arb #(.N(NCH)) u_arb (
    .req(ch_req),
    .any(arb_any),
    .idx(arb_idx)
  );

  assign start = arb_any & ~e_busy;

  dma_xfer_engine #(
    .NCH(NCH), .AW(AW), .DW(DW), .CW(CW), .MAXB(MAXB)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .start    (start),
    .start_ch (arb_idx),
    .c_src    (ch_src[arb_idx]),
    .c_dst    (ch_dst[arb_idx]),
    .c_cnt    (ch_cnt[arb_idx]),
    .c_next   (ch_next[arb_idx]),
    .c_mode   (ch_mode[arb_idx]),
    .c_dir    (ch_dir[arb_idx]),
    .dev_wdata(dev_wdata),
    .m_rdata  (m_rdata),
    .m_ack    (m_ack),
    .busy     (e_busy),
    .m_req    (m_req),
    .m_we     (m_we),
    .m_addr   (m_addr),
    .m_wdata  (m_wdata),
    .dev_ack  (dev_ack),
    .upd_en   (e_upd_en),
    .upd_ch   (e_upd_ch),
    .upd_fin  (e_upd_fin),
    .upd_src  (e_upd_src),
    .upd_dst  (e_upd_dst),
    .upd_cnt  (e_upd_cnt),
    .upd_next (e_upd_next),
    .irq      (irq)
  );

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int NCH  = 4,
  parameter int NEXT = 2,
  parameter int AW   = 32,
  parameter int MAXB = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           m_req,
  input logic           m_we,
  input logic           m_ack,
  input logic [AW-1:0]  m_addr,
  input logic [NCH-1:0] dev_ack,
  input logic [NCH-1:0] irq
);

  logic [7:0] run_q;
  logic       last_we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      last_we_q <= 1'b0;
    end else if (!m_req) begin
      run_q <= '0;
    end else if (m_ack) begin
      last_we_q <= m_we;
      if (run_q != '0 && m_we != last_we_q) run_q <= 8'd1;
      else run_q <= run_q + 8'd1;
    end
  end

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we)));

  // R2
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 8'(MAXB));

  // R7
  dack_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack != '0) |-> (m_req && $onehot0(dev_ack)));

  // R5
  dack_unpaced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack >> NEXT) == '0);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> (!m_req && $onehot0(irq)));

endmodule

bind dma_engine dma_engine_chk #(
  .NCH(NCH), .NEXT(NEXT), .AW(AW), .MAXB(MAXB)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .m_req  (m_req),
  .m_we   (m_we),
  .m_ack  (m_ack),
  .m_addr (m_addr),
  .dev_ack(dev_ack),
  .irq    (irq)
);

// File: tb/sim_dma_engine.sv
module sim_dma_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_ch;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [1:0]  ext_req;
  logic [31:0] dev_wdata;
  logic [3:0]  dev_ack, irq;
  logic        m_req, m_we, m_ack;
  logic [31:0] m_addr, m_wdata, m_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dma_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ext_req(ext_req), .dev_wdata(dev_wdata), .dev_ack(dev_ack),
    .irq(irq), .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_ack(m_ack)
  );

  // memory model
  logic [31:0] mem [1024];
  logic        init_go = 1'b0;
  logic        poke_we = 1'b0;
  logic [9:0]  poke_a  = '0;
  logic [31:0] poke_d  = '0;
  logic [15:0] lfsr    = 16'hACE1;
  logic        slow    = 1'b0;

  function automatic logic [31:0] pat(int i);
    return 32'h3C00_0000 ^ (32'(i) * 32'h0001_0203);
  endfunction

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (init_go) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
    end else if (poke_we) begin
      mem[poke_a] <= poke_d;
    end else if (m_req && m_we && m_ack) begin
      mem[m_addr[11:2]] <= m_wdata;
    end
  end

  assign m_ack   = m_req & (~slow | lfsr[0]);
  assign m_rdata = mem[m_addr[11:2]];

  // bus monitor
  int          rises = 0;
  int          wbeats = 0;
  int          dack_n [4];
  int          irq_n  [4];
  logic [31:0] rise_addr [256];
  logic [31:0] cap0 [256];
  logic        prev_req = 1'b0;

  initial for (int c = 0; c < 4; c++) begin dack_n[c] = 0; irq_n[c] = 0; end

  assign dev_wdata = 32'hA500_0000 + 32'(dack_n[1]);

  always @(posedge clk) begin
    prev_req <= m_req;
    if (m_req && !prev_req) begin
      rise_addr[rises % 256] <= m_addr;
      rises <= rises + 1;
    end
    if (m_req && m_we && m_ack) wbeats <= wbeats + 1;
    if (dev_ack[0] && m_ack) cap0[dack_n[0] % 256] <= m_rdata;
    for (int c = 0; c < 4; c++) begin
      if (dev_ack[c] && m_ack) dack_n[c] <= dack_n[c] + 1;
      if (irq[c]) irq_n[c] <= irq_n[c] + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input int sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 3'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int ch, input logic [31:0] src, input logic [31:0] dst,
                       input int cnt, input logic [31:0] nxt);
    cfg(ch, 0, src);
    cfg(ch, 1, dst);
    cfg(ch, 2, 32'(cnt));
    cfg(ch, 3, nxt);
  endtask

  task automatic go(input int ch, input int mode, input int dir);
    cfg(ch, 4, 32'(1 | (mode << 1) | (dir << 3)));
  endtask

  task automatic wait_irq(input int ch, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      if (irq[ch]) seen = 1'b1;
      @(negedge clk);
    end
    chk(seen, req, "completion pulse", 32'(seen), 32'd1);
  endtask

  task automatic reinit();
    init_go = 1'b1;
    @(negedge clk);
    init_go = 1'b0;
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    poke_we = 1'b1; poke_a = 10'(a); poke_d = d;
    @(negedge clk);
    poke_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int r0, w0, d0, i0, c0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ch = '0; cfg_sel = '0; cfg_wdata = '0; ext_req = '0;
    repeat (3) @(negedge clk);
    // R11 during reset
    chk(!m_req, "R11", "m_req in reset", 32'(m_req), 0);
    chk(irq == 0 && dev_ack == 0, "R11", "irq/dev_ack in reset", {24'd0, irq, dev_ack}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    r0 = rises;
    repeat (10) @(negedge clk);
    chk(rises == r0 && !m_req, "R11", "no traffic after reset", 32'(rises - r0), 0);

    // copy sweep: R1, R2, R10, R12
    slow = 1'b1;
    for (int len = 1; len <= 17; len++) begin
      int s = 16 + len * 3;
      int d = 400 + len * 20;
      int err = 0;
      reinit();
      r0 = rises;
      setup(2, 32'(s * 4), 32'(d * 4), len, 0);
      go(2, 0, 0);
      wait_irq(2, "R1");
      for (int k = 0; k < len; k++) if (mem[d + k] !== pat(s + k)) err++;
      chk(err == 0, "R1 R10", "copied words mismatching", 32'(err), 0);
      chk(mem[d + len] === pat(d + len) && mem[d - 1] === pat(d - 1), "R1",
          "guard words", mem[d + len], pat(d + len));
      chk(rises - r0 == (len + 7) / 8, "R2", "burst count", 32'(rises - r0), 32'((len + 7) / 8));
    end

    // fill sweep: R4, R12
    for (int len = 1; len <= 11; len++) begin
      int d = 200 + len * 16;
      int err = 0;
      logic [31:0] k32 = 32'hF111_0000 + 32'(len);
      reinit();
      w0 = wbeats;
      setup(3, k32, 32'(d * 4), len, 0);
      go(3, 1, 0);
      wait_irq(3, "R4");
      for (int k = 0; k < len; k++) if (mem[d + k] !== k32) err++;
      chk(err == 0, "R4 R12", "fill words mismatching", 32'(err), 0);
      chk(mem[d + len] === pat(d + len), "R4", "fill guard", mem[d + len], pat(d + len));
      chk(wbeats - w0 == len, "R4", "fill write beats", 32'(wbeats - w0), 32'(len));
    end

    // chain: R8, R9
    begin
      int err = 0;
      reinit();
      poke(900, 32'(64 * 4));
      poke(901, 32'(576 * 4));
      poke(902, 32'd5);
      poke(903, 32'd0);
      i0 = irq_n[1];
      setup(1, 32'(16 * 4), 32'(512 * 4), 3, 32'(900 * 4));
      go(1, 0, 0);
      wait_irq(1, "R8");
      for (int k = 0; k < 3; k++) if (mem[512 + k] !== pat(16 + k)) err++;
      for (int k = 0; k < 5; k++) if (mem[576 + k] !== pat(64 + k)) err++;
      chk(err == 0, "R8", "chained data mismatching", 32'(err), 0);
      repeat (20) @(negedge clk);
      chk(irq_n[1] - i0 == 1, "R9", "one pulse per chain", 32'(irq_n[1] - i0), 1);
    end

    // zero count, null pointer: R9
    r0 = rises; i0 = irq_n[3];
    setup(3, 32'h1234_5678, 32'(300 * 4), 0, 0);
    go(3, 1, 0);
    wait_irq(3, "R9");
    repeat (20) @(negedge clk);
    chk(rises == r0, "R9", "no bus access at count zero", 32'(rises - r0), 0);
    chk(irq_n[3] - i0 == 1, "R9", "channel disabled after pulse", 32'(irq_n[3] - i0), 1);

    // pacing and dual-address: R5, R6
    begin
      int err = 0;
      reinit();
      r0 = rises;
      setup(0, 32'(30 * 4), 32'(600 * 4), 10, 0);
      go(0, 2, 0);
      repeat (30) @(negedge clk);
      chk(rises == r0, "R5", "no access without request", 32'(rises - r0), 0);
      ext_req = 2'b01;
      wait_irq(0, "R6");
      ext_req = 2'b00;
      for (int k = 0; k < 10; k++) if (mem[600 + k] !== pat(30 + k)) err++;
      chk(err == 0, "R6", "dual words mismatching", 32'(err), 0);
    end

    // paced mode on a channel without a request pin: R5
    r0 = rises;
    setup(2, 32'(40 * 4), 32'(700 * 4), 4, 0);
    go(2, 2, 0);
    repeat (40) @(negedge clk);
    chk(rises == r0, "R5", "channel 2 paced never served", 32'(rises - r0), 0);
    chk(mem[700] === pat(700), "R5", "channel 2 destination untouched", mem[700], pat(700));
    cfg(2, 4, 0);

    // priority: R3
    slow = 1'b0;
    r0 = rises;
    setup(0, 32'(50 * 4), 32'(650 * 4), 3, 0);
    setup(1, 32'(60 * 4), 32'(660 * 4), 3, 0);
    go(1, 2, 0);
    go(0, 2, 0);
    ext_req = 2'b11;
    wait_irq(0, "R3");
    wait_irq(1, "R3");
    ext_req = 2'b00;
    chk(rise_addr[r0 % 256] == 32'(50 * 4), "R3", "first burst from channel 0",
        rise_addr[r0 % 256], 32'(50 * 4));
    chk(rise_addr[(r0 + 1) % 256] == 32'(60 * 4), "R3", "second burst from channel 1",
        rise_addr[(r0 + 1) % 256], 32'(60 * 4));

    // fly-by device to memory: R7
    begin
      int err = 0;
      slow = 1'b1;
      reinit();
      d0 = dack_n[1];
      setup(1, 0, 32'(700 * 4), 11, 0);
      ext_req = 2'b10;
      go(1, 3, 0);
      wait_irq(1, "R7");
      ext_req = 2'b00;
      for (int k = 0; k < 11; k++) if (mem[700 + k] !== 32'hA500_0000 + 32'(d0 + k)) err++;
      chk(err == 0, "R7", "fly-by write words mismatching", 32'(err), 0);
      chk(dack_n[1] - d0 == 11, "R7", "strobe count write", 32'(dack_n[1] - d0), 11);
      chk(mem[711] === pat(711), "R7", "fly-by guard", mem[711], pat(711));
    end

    // fly-by memory to device: R7
    begin
      int err = 0;
      c0 = dack_n[0]; w0 = wbeats;
      setup(0, 0, 32'(100 * 4), 9, 0);
      ext_req = 2'b01;
      go(0, 3, 1);
      wait_irq(0, "R7");
      ext_req = 2'b00;
      for (int k = 0; k < 9; k++) if (cap0[(c0 + k) % 256] !== pat(100 + k)) err++;
      chk(err == 0, "R7", "fly-by read words mismatching", 32'(err), 0);
      chk(dack_n[0] - c0 == 9, "R7", "strobe count read", 32'(dack_n[0] - c0), 9);
      chk(wbeats == w0, "R7", "no writes in fly-by read", 32'(wbeats - w0), 0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule